// File: doc/BRIEF.md
# Load-Linked Store-Conditional Reservation Monitor

This block holds the single load-linked reservation of one hardware thread. A load-linked request stores its physical address with the low granule bits cleared and arms a reservation flag. A coherence snoop from another agent disarms the flag when it lands in the same cache line. The line size is set by a mask input, so one build can serve several line sizes. Each store-conditional is judged against the reservation. The block returns whether the store may go to memory and a result code for the thread's result register.

Store-conditionals to uncacheable space skip the check entirely. The block also counts consecutive failed store-conditionals and emits a periodic livelock warning. A global clear-exclusive input becomes a one-cycle wakeup for the owning thread. Every decision is registered and appears one clock after its request, marked by a valid strobe.

Top module: `llsc_monitor`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all outputs are low. After reset no reservation exists, so a cacheable store-conditional fails.
- R2: A load-linked request records its address with the low GRAN_BITS (default 4) bits cleared and arms the reservation. A following cacheable store-conditional to any byte of that 16-byte granule passes with code 1 and issue high.
- R3: A cacheable store-conditional whose granule differs from the recorded one fails with code 0 and issue low. It also disarms the reservation.
- R4: A cacheable store-conditional while the reservation is disarmed fails with code 0 and issue low.
- R5: A passing store-conditional disarms the reservation, so an identical store-conditional that follows fails.
- R6: An uncacheable store-conditional yields code 2 with issue high. It leaves the reservation and the failure count unchanged.
- R7: A snoop whose address matches the recorded address under `line_mask` disarms an armed reservation. A snoop that differs under the mask has no effect. A snoop while disarmed has no effect.
- R8: When a load-linked and a matching snoop arrive in the same cycle, the load-linked wins: the reservation is armed at the new address.
- R9: When a cacheable store-conditional and a matching snoop arrive in the same cycle, the snoop takes effect first and the store-conditional fails.
- R10: Each failed cacheable store-conditional advances a consecutive-failure count, and a passing one resets it to zero. `livelock_warn` pulses for one cycle, together with the failing decision, whenever the new count is a nonzero multiple of WARN_PERIOD.
- R11: A clear-exclusive pulse produces a one-cycle `wakeup` in the next cycle.
- R12: Decisions appear exactly one cycle after `sc_valid`, with `dec_valid` high for that one cycle. In cycles without a decision, `dec_valid` and `dec_issue` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ll_valid | input | 1 | Load-linked request |
| ll_addr | input | ADDR_W | Load-linked physical address |
| snoop_valid | input | 1 | Snoop from another agent |
| snoop_addr | input | ADDR_W | Snoop address |
| line_mask | input | ADDR_W | Cache-line mask applied to snoop comparison |
| sc_valid | input | 1 | Store-conditional request |
| sc_addr | input | ADDR_W | Store-conditional physical address |
| sc_uncached | input | 1 | Store-conditional targets uncacheable space |
| clrex | input | 1 | Global clear-exclusive event |
| dec_valid | output | 1 | Decision strobe |
| dec_issue | output | 1 | Store may be sent to memory |
| dec_code | output | 2 | Result code: 0 fail, 1 pass, 2 uncached bypass |
| livelock_warn | output | 1 | Periodic consecutive-failure warning |
| wakeup | output | 1 | Wakeup for the owning thread |

## Verification
Two pairs of functions can meet in one cycle. A load-linked can coincide with a snoop to the same line, and a store-conditional can coincide with a matching snoop. The bench drives both inputs on the same falling edge and judges the result by the next store-conditional decision, or by that same decision. A reference model of the reservation, written from the requirements, predicts the outcome. A long pseudo-random run over a narrow address window with a small warning period makes these collisions frequent. The same run also carries warning wraps and mixed uncached traffic.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    SC_FAIL   = 2'd0,
    SC_PASS   = 2'd1,
    SC_BYPASS = 2'd2
  } sc_code_e;
endpackage

// File: rtl/llsc_resv.sv
module llsc_resv #(
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ll_valid,
  input  logic [ADDR_W-1:0] ll_addr,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic [ADDR_W-1:0] line_mask,
  input  logic              sc_consume,
  output logic              resv_live,
  output logic [ADDR_W-1:0] resv_addr
);
  localparam logic [ADDR_W-1:0] GRAN_MASK = ~((ADDR_W'(1) << GRAN_BITS) - ADDR_W'(1));

  logic              flag_q, flag_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;
  logic              snoop_hit;

  always_comb begin
    snoop_hit = snoop_valid && flag_q &&
                ((addr_q & line_mask) == (snoop_addr & line_mask));
    addr_en   = ll_valid;
    addr_d    = ll_addr & GRAN_MASK;
    if (ll_valid)        flag_d = 1'b1;
    else if (sc_consume) flag_d = 1'b0;
    else if (snoop_hit)  flag_d = 1'b0;
    else                 flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      addr_q <= '0;
    end else begin
      flag_q <= flag_d;
      if (addr_en) addr_q <= addr_d;
    end
  end

  assign resv_live = flag_q && !snoop_hit;
  assign resv_addr = addr_q;

  p_ll_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ll_valid |=> flag_q && (addr_q[GRAN_BITS-1:0] == '0) &&
                 (addr_q[ADDR_W-1:GRAN_BITS] == $past(ll_addr[ADDR_W-1:GRAN_BITS])));
  p_snoop_kill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_hit && !ll_valid) |=> !flag_q);
  p_ll_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ll_valid && snoop_valid) |=> flag_q);
endmodule

// File: rtl/llsc_fail_ctr.sv
module llsc_fail_ctr #(
  parameter int WARN_PERIOD = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fail_ev,
  input  logic pass_ev,
  output logic warn_ev
);
  localparam int CNT_W = (WARN_PERIOD > 1) ? $clog2(WARN_PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WARN_PERIOD - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    warn_ev = fail_ev && (cnt_q == LAST);
    cnt_en  = fail_ev || pass_ev;
    if (pass_ev)      cnt_d = '0;
    else if (warn_ev) cnt_d = '0;
    else              cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  p_pass_resets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pass_ev |=> cnt_q == '0);
  p_excl_ev_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(fail_ev && pass_ev));
endmodule

// File: rtl/llsc_judge.sv
module llsc_judge
  import llsc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 4
) (
  input  logic              sc_valid,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic              sc_uncached,
  input  logic              resv_live,
  input  logic [ADDR_W-1:0] resv_addr,
  output logic              issue,
  output sc_code_e          code,
  output logic              fail_ev,
  output logic              pass_ev,
  output logic              consume
);
  logic gran_match;

  always_comb begin
    gran_match = sc_addr[ADDR_W-1:GRAN_BITS] == resv_addr[ADDR_W-1:GRAN_BITS];
    consume    = sc_valid && !sc_uncached;
    pass_ev    = consume && resv_live && gran_match;
    fail_ev    = consume && !pass_ev;
    if (sc_valid && sc_uncached) begin
      issue = 1'b1;
      code  = SC_BYPASS;
    end else if (pass_ev) begin
      issue = 1'b1;
      code  = SC_PASS;
    end else begin
      issue = 1'b0;
      code  = SC_FAIL;
    end
  end

  a_judge_r3: assert final (!(fail_ev && issue));
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int GRAN_BITS   = 4,
  parameter int WARN_PERIOD = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ll_valid,
  input  logic [ADDR_W-1:0] ll_addr,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic [ADDR_W-1:0] line_mask,
  input  logic              sc_valid,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic              sc_uncached,
  input  logic              clrex,
  output logic              dec_valid,
  output logic              dec_issue,
  output logic [1:0]        dec_code,
  output logic              livelock_warn,
  output logic              wakeup
);
  logic              resv_live;
  logic [ADDR_W-1:0] resv_addr;
  logic              issue, fail_ev, pass_ev, consume, warn_ev;
  sc_code_e          code;

  logic       valid_d, issue_d, warn_d, wake_d;
  logic [1:0] code_d;

  llsc_resv #(.ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS)) u_resv (
    .clk(clk), .rst_n(rst_n),
    .ll_valid(ll_valid), .ll_addr(ll_addr),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .line_mask(line_mask),
    .sc_consume(consume),
    .resv_live(resv_live), .resv_addr(resv_addr)
  );

  llsc_judge #(.ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS)) u_judge (
    .sc_valid(sc_valid), .sc_addr(sc_addr), .sc_uncached(sc_uncached),
    .resv_live(resv_live), .resv_addr(resv_addr),
    .issue(issue), .code(code),
    .fail_ev(fail_ev), .pass_ev(pass_ev), .consume(consume)
  );

  llsc_fail_ctr #(.WARN_PERIOD(WARN_PERIOD)) u_fail (
    .clk(clk), .rst_n(rst_n),
    .fail_ev(fail_ev), .pass_ev(pass_ev),
    .warn_ev(warn_ev)
  );

  always_comb begin
    valid_d = sc_valid;
    issue_d = sc_valid && issue;
    code_d  = sc_valid ? code : SC_FAIL;
    warn_d  = warn_ev;
    wake_d  = clrex;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid     <= 1'b0;
      dec_issue     <= 1'b0;
      dec_code      <= SC_FAIL;
      livelock_warn <= 1'b0;
      wakeup        <= 1'b0;
    end else begin
      dec_valid     <= valid_d;
      dec_issue     <= issue_d;
      dec_code      <= code_d;
      livelock_warn <= warn_d;
      wakeup        <= wake_d;
    end
  end

  p_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sc_valid |=> dec_valid);
  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !sc_valid |=> !dec_valid && !dec_issue);
  p_fail_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_code == SC_FAIL) |-> !dec_issue);
  p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && sc_uncached) |=> dec_issue && dec_code == SC_BYPASS);
  p_warn_on_fail_r10: assert property (@(posedge clk) disable iff (!rst_n)
    livelock_warn |-> dec_valid && dec_code == SC_FAIL);
  p_wakeup_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clrex |=> wakeup);
endmodule

// File: tb/llsc_monitor_test.sv
module llsc_monitor_test;
  localparam int AW = 16;
  localparam int P  = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic ll_valid, snoop_valid, sc_valid, sc_uncached, clrex;
  logic [AW-1:0] ll_addr, snoop_addr, line_mask, sc_addr;
  logic dec_valid, dec_issue, livelock_warn, wakeup;
  logic [1:0] dec_code;

  int nvec = 0, nfail = 0;
  bit done = 0;

  bit            m_flag;
  logic [AW-1:0] m_addr;
  int            m_cnt;

  always #5 clk = ~clk;

  llsc_monitor #(.ADDR_W(AW), .GRAN_BITS(4), .WARN_PERIOD(P)) uut (
    .clk(clk), .rst_n(rst_n),
    .ll_valid(ll_valid), .ll_addr(ll_addr),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .line_mask(line_mask),
    .sc_valid(sc_valid), .sc_addr(sc_addr), .sc_uncached(sc_uncached),
    .clrex(clrex),
    .dec_valid(dec_valid), .dec_issue(dec_issue), .dec_code(dec_code),
    .livelock_warn(livelock_warn), .wakeup(wakeup)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit ll, input logic [AW-1:0] lla,
                      input bit sn, input logic [AW-1:0] sna,
                      input bit sc, input logic [AW-1:0] sca, input bit unc,
                      input bit clr, input string tag);
    bit hit, live, pass, e_issue, e_warn;
    logic [1:0] e_code;
    @(negedge clk);
    ll_valid = ll; ll_addr = lla; snoop_valid = sn; snoop_addr = sna;
    sc_valid = sc; sc_addr = sca; sc_uncached = unc; clrex = clr;
    hit  = sn && m_flag && ((m_addr & line_mask) == (sna & line_mask));
    live = m_flag && !hit;
    e_issue = 0; e_code = 2'd0; e_warn = 0;
    if (sc && unc) begin
      e_issue = 1; e_code = 2'd2;
    end else if (sc) begin
      pass = live && ((sca & 16'hFFF0) == m_addr);
      e_issue = pass; e_code = pass ? 2'd1 : 2'd0;
      if (pass) m_cnt = 0;
      else begin
        m_cnt++;
        if (m_cnt == P) begin e_warn = 1; m_cnt = 0; end
      end
    end
    if (ll) begin m_flag = 1; m_addr = lla & 16'hFFF0; end
    else if (sc && !unc) m_flag = 0;
    else if (hit) m_flag = 0;
    @(posedge clk); #1;
    chk(tag, "dec_valid", dec_valid, sc);
    chk(tag, "dec_issue", dec_issue, e_issue);
    if (sc) chk(tag, "dec_code", dec_code, e_code);
    chk(tag, "livelock_warn", livelock_warn, e_warn);
    chk(tag, "wakeup", wakeup, clr);
  endtask

  task automatic idle(input string tag);
    step(0, '0, 0, '0, 0, '0, 0, 0, tag);
  endtask

  task automatic sc_only(input logic [AW-1:0] a, input string tag);
    step(0, '0, 0, '0, 1, a, 0, 0, tag);
  endtask

  task automatic ll_only(input logic [AW-1:0] a, input string tag);
    step(1, a, 0, '0, 0, '0, 0, 0, tag);
  endtask

  task automatic report;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      nfail++;
      $display("FAIL R12 watchdog: actual hung expected finished");
      report();
      $finish;
    end
  end

  initial begin
    logic [31:0] lcg;
    rst_n = 0; line_mask = 16'hFFC0;
    ll_valid = 0; snoop_valid = 0; sc_valid = 0; sc_uncached = 0; clrex = 0;
    ll_addr = '0; snoop_addr = '0; sc_addr = '0;
    m_flag = 0; m_addr = '0; m_cnt = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs quiet during reset
    chk("R1", "outputs in reset", {dec_valid, dec_issue, dec_code, livelock_warn, wakeup}, 0);
    @(negedge clk); rst_n = 1;
    idle("R1");
    sc_only(16'h0100, "R1");          // no reservation after reset
    sc_only(16'h0100, "R4");

    // R2 / R5: every byte of the granule passes, the repeat fails
    for (int off = 0; off < 16; off++) begin
      ll_only(16'h1230 + 16'(off ^ 5), "R2");
      sc_only(16'h1230 + 16'(off), "R2");
      sc_only(16'h1230 + 16'(off), "R5");
    end

    // R3: neighbouring granules fail and disarm
    for (int g = 1; g < 8; g++) begin
      ll_only(16'h2000, "R3");
      sc_only(16'h2000 + 16'(g * 16), "R3");
      sc_only(16'h2000, "R3");
    end

    // R6: uncached bypass leaves reservation intact
    ll_only(16'h3050, "R6");
    step(0, '0, 0, '0, 1, 16'h7777, 1, 0, "R6");
    sc_only(16'h305C, "R6");

    // R7: snoop hit, miss, and with flag clear
    ll_only(16'h1000, "R7");
    step(0, '0, 1, 16'h1030, 0, '0, 0, 0, "R7");
    sc_only(16'h1000, "R7");
    ll_only(16'h1000, "R7");
    step(0, '0, 1, 16'h1040, 0, '0, 0, 0, "R7");
    sc_only(16'h1000, "R7");
    step(0, '0, 1, 16'h1000, 0, '0, 0, 0, "R7");
    ll_only(16'h1000, "R7");
    sc_only(16'h1000, "R7");
    line_mask = 16'hFF00;
    ll_only(16'h1010, "R7");
    step(0, '0, 1, 16'h10C0, 0, '0, 0, 0, "R7");
    sc_only(16'h1010, "R7");
    line_mask = 16'hFFC0;

    // R8: load-linked beats same-cycle matching snoop
    ll_only(16'h4000, "R8");
    step(1, 16'h4010, 1, 16'h4000, 0, '0, 0, 0, "R8");
    sc_only(16'h4018, "R8");

    // R9: same-cycle snoop hit kills the store-conditional
    ll_only(16'h5000, "R9");
    step(0, '0, 1, 16'h5020, 1, 16'h5000, 0, 0, "R9");
    ll_only(16'h5000, "R9");
    step(0, '0, 1, 16'h9000, 1, 16'h5000, 0, 0, "R9");

    // R10: warning cadence and reset by a pass
    for (int k = 0; k < 3 * P + 2; k++) sc_only(16'h0200, "R10");
    ll_only(16'h0200, "R10");
    sc_only(16'h0200, "R10");
    for (int k = 0; k < P; k++) begin
      step(0, '0, 0, '0, 1, 16'h0300, k == 2, 0, "R10");
    end
    sc_only(16'h0200, "R10");

    // R11: clear-exclusive wakeup, single and back to back
    step(0, '0, 0, '0, 0, '0, 0, 1, "R11");
    idle("R11");
    step(0, '0, 0, '0, 0, '0, 0, 1, "R11");
    step(0, '0, 0, '0, 0, '0, 0, 1, "R11");
    idle("R11");

    // R12: pseudo-random mix over a narrow window
    lcg = 32'h1234_5678;
    for (int i = 0; i < 3000; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      if (i == 1500) line_mask = 16'hFFE0;
      step(lcg[31:29] == 0, 16'h6000 | 16'(lcg[7:0]),
           lcg[28:27] == 0, 16'h6000 | 16'(lcg[15:8]),
           lcg[26:25] != 0, 16'h6000 | 16'(lcg[23:16] & 8'h3F),
           lcg[24:21] == 0, lcg[20:18] == 0, "R12");
    end

    done = 1;
    report();
    $finish;
  end
endmodule